// File: doc/BRIEF.md
# Multi-Queue Work Dispatch Manager

This block collects work descriptors from many independent submission queues, plus a child-work port used by work that is already running, and hands them one at a time to a pool of execution units. Every descriptor gets a slot in a shared table of active entries. The slot number is the entry ID that travels with the dispatch and that the execution side returns on completion.

Each queue is dispatched strictly in the order it was submitted. Queues never wait on one another, so a queue with nothing ready, or a queue with a deep backlog, does not hold up the others. Child work and resumed parents form an internal class, which is served ahead of host queue heads.

A running entry may spawn children. If it completes while any of its children are still outstanding, it is parked in a suspended state. When its last child completes, it is offered for dispatch again under the same ID so that it can resume. A pause input freezes dispatch while admission continues, and nothing held in the table is lost.

Top module: `wq_dispatch_mgr`

## Requirements
- R1: After reset the table is empty: `disp_valid` is low, `sub_ready` is all zero, and `kid_ready` is high.
- R2: Descriptors from one queue are offered for dispatch in the order that queue had them accepted, and only an entry in the ready state is ever offered.
- R3: Among queues whose oldest undispatched entry is waiting, dispatch rotates round-robin. The queue granted next is the first one at or above the index following the last host queue dispatched, wrapping to 0, and the pointer starts at 0 after reset. No queue waits on another queue's entries.
- R4: Internal work (child descriptors and resumed parents) is offered ahead of any host queue head, lowest slot first. A dispatched entry becomes running on the accepting edge.
- R5: At most one descriptor is admitted per cycle. The child port wins. Otherwise queues are granted round-robin: the first valid queue at or above the index following the last admitted queue, wrapping. `sub_ready` is one-hot on the granted queue.
- R6: The table holds DEPTH entries. When every slot is occupied, all `sub_ready` bits and `kid_ready` are low, and a waiting descriptor stays held by its submitter until a slot frees.
- R7: While `pause` is high, `disp_valid` is low and admission continues. After release, every held entry is dispatched.
- R8: A child submission raises its parent's outstanding-child count. A parent that completes with a nonzero count is suspended and is not offered. When its last child completes, the parent is offered again with its original ID and descriptor.
- R9: A completion for an entry with no outstanding children frees its slot. A new descriptor takes the lowest free slot, so a freed ID is reused.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sub_valid | input | NUM_Q | Per-queue descriptor valid |
| sub_ready | output | NUM_Q | Per-queue accept, one-hot when set |
| sub_desc | input | NUM_Q*DESC_W | Per-queue descriptor payload, queue q at bits q*DESC_W upward |
| kid_valid | input | 1 | Child descriptor valid |
| kid_ready | output | 1 | Child descriptor accept |
| kid_parent | input | log2(DEPTH) | ID of the running parent that spawns the child |
| kid_desc | input | DESC_W | Child descriptor payload |
| disp_valid | output | 1 | An entry is offered for dispatch |
| disp_ready | input | 1 | Execution side takes the offered entry |
| disp_id | output | log2(DEPTH) | Table slot of the offered entry |
| disp_desc | output | DESC_W | Descriptor of the offered entry |
| done_valid | input | 1 | A running entry has completed |
| done_id | input | log2(DEPTH) | ID of the completing entry |
| pause | input | 1 | Hold dispatch of new entries |

## Verification
A corrupted per-queue sequence counter would show up at the dispatch port as a queue going silent or emitting out of order. The scoreboard catches this on the very next accepted dispatch, because it compares every descriptor against an order worked out from the round-robin and precedence rules. A miscounted child total would either re-offer a suspended parent too early, which the bench sees within a cycle of the parent's completion, or never re-offer it, which drains the scoreboard late and trips the timeout. Slot leaks appear as ready held low before the table really holds DEPTH entries, and ID reuse is checked directly against the lowest freed slot.

// File: rtl/wdm_pkg.sv
package wdm_pkg;

    // lifecycle of one table slot
    typedef enum logic [1:0] {
        SLOT_FREE  = 2'd0,
        SLOT_READY = 2'd1,
        SLOT_RUN   = 2'd2,
        SLOT_WAIT  = 2'd3
    } slot_state_e;

    // increment with wrap at n
    function automatic int wrap_inc(input int v, input int n);
        return (v >= n - 1) ? 0 : v + 1;
    endfunction

endpackage

// File: rtl/wdm_first_set.sv
module wdm_first_set #(
    parameter int N = 8,
    localparam int W = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0] vec,
    output logic         any,
    output logic [W-1:0] idx
);

    // lowest set bit wins
    always_comb begin
        any = 1'b0;
        idx = '0;
        for (int k = N - 1; k >= 0; k--) begin
            if (vec[k]) begin
                any = 1'b1;
                idx = W'(k);
            end
        end
    end

endmodule

// File: rtl/wdm_rr_arb.sv
module wdm_rr_arb
    import wdm_pkg::*;
#(
    parameter int N = 8,
    localparam int W = (N > 1) ? $clog2(N) : 1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] req,
    input  logic         adv,
    output logic         any,
    output logic [W-1:0] idx
);

    logic [W-1:0] ptr;
    logic [N-1:0] upper;
    logic         up_any;
    logic [W-1:0] up_idx;
    logic [W-1:0] lo_idx;

    always_comb begin
        for (int k = 0; k < N; k++) begin
            upper[k] = req[k] && (W'(k) >= ptr);
        end
    end

    wdm_first_set #(.N(N)) u_upper (.vec(upper), .any(up_any), .idx(up_idx));
    wdm_first_set #(.N(N)) u_all   (.vec(req),   .any(any),    .idx(lo_idx));

    assign idx = up_any ? up_idx : lo_idx;

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr <= '0;
        end else if (adv && any) begin
            ptr <= W'(wrap_inc(int'(idx), N));
        end
    end

endmodule

// File: rtl/wdm_head_scan.sv
module wdm_head_scan #(
    parameter int NUM_Q = 4,
    parameter int DEPTH = 8,
    localparam int QW = $clog2(NUM_Q),
    localparam int IW = $clog2(DEPTH),
    localparam int SW = IW + 1
) (
    input  logic [DEPTH-1:0]         cand,
    input  logic [DEPTH-1:0][QW-1:0] slot_q,
    input  logic [DEPTH-1:0][SW-1:0] slot_seq,
    input  logic [NUM_Q-1:0][SW-1:0] want,
    output logic [NUM_Q-1:0]         head_any,
    output logic [NUM_Q-1:0][IW-1:0] head_slot
);

    // per queue: the ready host entry carrying the next sequence number
    for (genvar g = 0; g < NUM_Q; g++) begin : g_q
        logic [DEPTH-1:0] hit;
        logic             f_any;
        logic [IW-1:0]    f_idx;

        always_comb begin
            for (int k = 0; k < DEPTH; k++) begin
                hit[k] = cand[k] && (slot_q[k] == QW'(g)) && (slot_seq[k] == want[g]);
            end
        end

        wdm_first_set #(.N(DEPTH)) u_fs (.vec(hit), .any(f_any), .idx(f_idx));

        assign head_any[g]  = f_any;
        assign head_slot[g] = f_idx;
    end

endmodule

// File: rtl/wq_dispatch_mgr.sv
module wq_dispatch_mgr
    import wdm_pkg::*;
#(
    parameter int NUM_Q  = 32,
    parameter int DEPTH  = 32,
    parameter int DESC_W = 16,
    localparam int IW = $clog2(DEPTH)
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic [NUM_Q-1:0]              sub_valid,
    output logic [NUM_Q-1:0]              sub_ready,
    input  logic [NUM_Q-1:0][DESC_W-1:0]  sub_desc,
    input  logic                          kid_valid,
    output logic                          kid_ready,
    input  logic [IW-1:0]                 kid_parent,
    input  logic [DESC_W-1:0]             kid_desc,
    output logic                          disp_valid,
    input  logic                          disp_ready,
    output logic [IW-1:0]                 disp_id,
    output logic [DESC_W-1:0]             disp_desc,
    input  logic                          done_valid,
    input  logic [IW-1:0]                 done_id,
    input  logic                          pause
);

    localparam int QW = $clog2(NUM_Q);
    localparam int SW = IW + 1;   // one spare bit so DEPTH in flight never aliases
    localparam int CW = IW + 1;   // outstanding child counter

    typedef struct packed {
        slot_state_e        st;
        logic               internal;
        logic [QW-1:0]      q;
        logic [SW-1:0]      seq;
        logic               has_par;
        logic [IW-1:0]      par;
        logic [CW-1:0]      kids;
        logic [DESC_W-1:0]  desc;
    } entry_t;

    entry_t ent   [DEPTH];
    entry_t ent_n [DEPTH];

    logic [NUM_Q-1:0][SW-1:0] enq_seq;
    logic [NUM_Q-1:0][SW-1:0] deq_seq;

    logic [DEPTH-1:0]         occ_vec;
    logic [DEPTH-1:0]         rdy_vec;
    logic [DEPTH-1:0]         run_vec;
    logic [DEPTH-1:0]         int_vec;
    logic [DEPTH-1:0]         host_vec;
    logic [DEPTH-1:0][QW-1:0] slot_q;
    logic [DEPTH-1:0][SW-1:0] slot_seq;

    // ---------------- slot views ----------------
    always_comb begin
        for (int i = 0; i < DEPTH; i++) begin
            occ_vec[i]  = (ent[i].st != SLOT_FREE);
            rdy_vec[i]  = (ent[i].st == SLOT_READY);
            run_vec[i]  = (ent[i].st == SLOT_RUN);
            int_vec[i]  = (ent[i].st == SLOT_READY) &&  ent[i].internal;
            host_vec[i] = (ent[i].st == SLOT_READY) && !ent[i].internal;
            slot_q[i]   = ent[i].q;
            slot_seq[i] = ent[i].seq;
        end
    end

    // ---------------- admission ----------------
    logic          free_any;
    logic [IW-1:0] free_idx;
    logic          adm_any;
    logic [QW-1:0] adm_idx;
    logic          kid_fire;
    logic          host_fire;
    logic          alloc;

    wdm_first_set #(.N(DEPTH)) u_free (.vec(~occ_vec), .any(free_any), .idx(free_idx));

    wdm_rr_arb #(.N(NUM_Q)) u_adm (
        .clk (clk),
        .rst (rst),
        .req (sub_valid),
        .adv (host_fire),
        .any (adm_any),
        .idx (adm_idx)
    );

    assign kid_ready = free_any;
    assign kid_fire  = kid_valid && free_any;
    assign host_fire = free_any && !kid_valid && adm_any;
    assign alloc     = kid_fire || host_fire;
    assign sub_ready = host_fire ? (NUM_Q'(1) << adm_idx) : '0;

    // ---------------- dispatch selection ----------------
    logic                     int_any;
    logic [IW-1:0]            int_idx;
    logic [NUM_Q-1:0]         head_any;
    logic [NUM_Q-1:0][IW-1:0] head_slot;
    logic                     dsp_any;
    logic [QW-1:0]            dsp_idx;
    logic [IW-1:0]            sel;
    logic                     disp_fire;
    logic                     host_disp_fire;

    wdm_first_set #(.N(DEPTH)) u_int (.vec(int_vec), .any(int_any), .idx(int_idx));

    wdm_head_scan #(.NUM_Q(NUM_Q), .DEPTH(DEPTH)) u_heads (
        .cand      (host_vec),
        .slot_q    (slot_q),
        .slot_seq  (slot_seq),
        .want      (deq_seq),
        .head_any  (head_any),
        .head_slot (head_slot)
    );

    wdm_rr_arb #(.N(NUM_Q)) u_disp (
        .clk (clk),
        .rst (rst),
        .req (head_any),
        .adv (host_disp_fire),
        .any (dsp_any),
        .idx (dsp_idx)
    );

    assign sel            = int_any ? int_idx : head_slot[dsp_idx];
    assign disp_valid     = !pause && (int_any || dsp_any);
    assign disp_id        = sel;
    assign disp_desc      = ent[sel].desc;
    assign disp_fire      = disp_valid && disp_ready;
    assign host_disp_fire = disp_fire && !int_any;

    // ---------------- completion ----------------
    logic          done_hit;
    logic          kid_to_done;
    logic [CW-1:0] done_kids;
    logic          done_frees;

    assign done_hit    = done_valid && (ent[done_id].st == SLOT_RUN);
    assign kid_to_done = kid_fire && (kid_parent == done_id);
    assign done_kids   = ent[done_id].kids + CW'(kid_to_done);
    assign done_frees  = done_hit && (done_kids == '0);

    // ---------------- next state ----------------
    always_comb begin
        logic          inc_k;
        logic          dec_k;
        logic [CW-1:0] kn;
        for (int i = 0; i < DEPTH; i++) begin
            ent_n[i] = ent[i];
            inc_k = kid_fire && (kid_parent == IW'(i));
            dec_k = done_frees && ent[done_id].has_par && (ent[done_id].par == IW'(i));
            kn    = ent[i].kids + CW'(inc_k) - CW'(dec_k);
            ent_n[i].kids = kn;
            if (alloc && (free_idx == IW'(i))) begin
                ent_n[i].st       = SLOT_READY;
                ent_n[i].internal = kid_fire;
                ent_n[i].q        = kid_fire ? '0 : adm_idx;
                ent_n[i].seq      = kid_fire ? '0 : enq_seq[adm_idx];
                ent_n[i].has_par  = kid_fire;
                ent_n[i].par      = kid_fire ? kid_parent : '0;
                ent_n[i].kids     = '0;
                ent_n[i].desc     = kid_fire ? kid_desc : sub_desc[adm_idx];
            end else if (disp_fire && (sel == IW'(i))) begin
                ent_n[i].st = SLOT_RUN;
            end else if (done_hit && (done_id == IW'(i))) begin
                if (kn == '0) begin
                    ent_n[i].st = SLOT_FREE;
                end else begin
                    ent_n[i].st       = SLOT_WAIT;
                    ent_n[i].internal = 1'b1;
                end
            end else if ((ent[i].st == SLOT_WAIT) && (kn == '0)) begin
                ent_n[i].st = SLOT_READY;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) begin
                ent[i] <= '0;
            end
            enq_seq <= '0;
            deq_seq <= '0;
        end else begin
            for (int i = 0; i < DEPTH; i++) begin
                ent[i] <= ent_n[i];
            end
            if (host_fire) begin
                enq_seq[adm_idx] <= enq_seq[adm_idx] + SW'(1);
            end
            if (host_disp_fire) begin
                deq_seq[dsp_idx] <= deq_seq[dsp_idx] + SW'(1);
            end
        end
    end

endmodule

// File: rtl/wq_dispatch_mgr_chk.sv
module wq_dispatch_mgr_chk #(
    parameter int NUM_Q = 32,
    parameter int DEPTH = 32,
    localparam int IW = $clog2(DEPTH)
) (
    input logic             clk,
    input logic             rst,
    input logic [NUM_Q-1:0] sub_valid,
    input logic [NUM_Q-1:0] sub_ready,
    input logic             kid_valid,
    input logic             kid_ready,
    input logic             disp_valid,
    input logic             disp_ready,
    input logic [IW-1:0]    disp_id,
    input logic             done_valid,
    input logic [IW-1:0]    done_id,
    input logic             pause,
    input logic [DEPTH-1:0] occ_vec,
    input logic [DEPTH-1:0] rdy_vec,
    input logic [DEPTH-1:0] run_vec
);

    // R6
    full_blocks_chk: assert property (@(posedge clk) disable iff (rst)
        (&occ_vec) |-> ((sub_ready == '0) && !kid_ready));

    // R5
    one_admit_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(sub_valid & sub_ready) &&
        !(kid_valid && kid_ready && (|(sub_valid & sub_ready))));

    // R7
    pause_hold_chk: assert property (@(posedge clk) disable iff (rst)
        pause |-> !disp_valid);

    // R2
    offer_ready_chk: assert property (@(posedge clk) disable iff (rst)
        disp_valid |-> rdy_vec[disp_id]);

    // R4
    fire_runs_chk: assert property (@(posedge clk) disable iff (rst)
        (disp_valid && disp_ready) |=> run_vec[$past(disp_id)]);

    // R9
    done_leaves_chk: assert property (@(posedge clk) disable iff (rst)
        (done_valid && run_vec[done_id] && !(disp_valid && disp_ready)) |=> !run_vec[$past(done_id)]);

endmodule

bind wq_dispatch_mgr wq_dispatch_mgr_chk #(.NUM_Q(NUM_Q), .DEPTH(DEPTH)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .sub_valid  (sub_valid),
    .sub_ready  (sub_ready),
    .kid_valid  (kid_valid),
    .kid_ready  (kid_ready),
    .disp_valid (disp_valid),
    .disp_ready (disp_ready),
    .disp_id    (disp_id),
    .done_valid (done_valid),
    .done_id    (done_id),
    .pause      (pause),
    .occ_vec    (occ_vec),
    .rdy_vec    (rdy_vec),
    .run_vec    (run_vec)
);

// File: tb/test_wq_dispatch_mgr.sv
module test_wq_dispatch_mgr;

    localparam int CLK_PERIOD = 10;
    localparam int NQ  = 32;
    localparam int DEP = 32;
    localparam int DW  = 16;
    localparam int IW  = $clog2(DEP);

    logic                 clk = 1'b0;
    logic                 rst;
    logic [NQ-1:0]        sub_valid;
    logic [NQ-1:0]        sub_ready;
    logic [NQ-1:0][DW-1:0] sub_desc;
    logic                 kid_valid;
    logic                 kid_ready;
    logic [IW-1:0]        kid_parent;
    logic [DW-1:0]        kid_desc;
    logic                 disp_valid;
    logic                 disp_ready;
    logic [IW-1:0]        disp_id;
    logic [DW-1:0]        disp_desc;
    logic                 done_valid;
    logic [IW-1:0]        done_id;
    logic                 pause;

    int checks = 0;
    int errors = 0;
    string cur_req = "R2";
    logic [DW-1:0] exp_q [$];
    int id_of [int];

    always #(CLK_PERIOD / 2) clk = ~clk;

    wq_dispatch_mgr #(.NUM_Q(NQ), .DEPTH(DEP), .DESC_W(DW)) i_wq_dispatch_mgr (
        .clk        (clk),
        .rst        (rst),
        .sub_valid  (sub_valid),
        .sub_ready  (sub_ready),
        .sub_desc   (sub_desc),
        .kid_valid  (kid_valid),
        .kid_ready  (kid_ready),
        .kid_parent (kid_parent),
        .kid_desc   (kid_desc),
        .disp_valid (disp_valid),
        .disp_ready (disp_ready),
        .disp_id    (disp_id),
        .disp_desc  (disp_desc),
        .done_valid (done_valid),
        .done_id    (done_id),
        .pause      (pause)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic expect_desc(input logic [DW-1:0] d);
        exp_q.push_back(d);
    endtask

    // scoreboard monitor: every accepted dispatch is compared in order
    always @(negedge clk) begin
        if (!rst && disp_valid && disp_ready) begin
            checks++;
            if (exp_q.size() == 0) begin
                errors++;
                $display("FAIL %s: unexpected dispatch %0h expected none", cur_req, disp_desc);
            end else begin
                logic [DW-1:0] e;
                e = exp_q.pop_front();
                if (disp_desc != e) begin
                    errors++;
                    $display("FAIL %s: dispatched %0h expected %0h", cur_req, disp_desc, e);
                end
            end
            id_of[int'(disp_desc)] = int'(disp_id);
        end
    end

    task automatic submit(input int q, input logic [DW-1:0] d);
        @(posedge clk); #1;
        sub_valid[q] = 1'b1;
        sub_desc[q]  = d;
        do @(negedge clk); while (!sub_ready[q]);
        @(posedge clk); #1;
        sub_valid[q] = 1'b0;
    endtask

    task automatic spawn(input int parent, input logic [DW-1:0] d);
        @(posedge clk); #1;
        kid_valid  = 1'b1;
        kid_parent = IW'(parent);
        kid_desc   = d;
        do @(negedge clk); while (!kid_ready);
        @(posedge clk); #1;
        kid_valid = 1'b0;
    endtask

    task automatic complete(input int id);
        @(posedge clk); #1;
        done_valid = 1'b1;
        done_id    = IW'(id);
        @(posedge clk); #1;
        done_valid = 1'b0;
    endtask

    task automatic drain();
        while (exp_q.size() != 0) @(negedge clk);
        @(posedge clk); #1;
    endtask

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: run did not end, actual timeout expected completion");
        summary();
    end

    initial begin
        int pid;
        int pid2;
        rst = 1'b1;
        sub_valid = '0; sub_desc = '0;
        kid_valid = 1'b0; kid_parent = '0; kid_desc = '0;
        disp_ready = 1'b0; done_valid = 1'b0; done_id = '0; pause = 1'b0;
        repeat (5) @(posedge clk);
        #1 rst = 1'b0;

        // R1: empty after reset
        @(negedge clk);
        check(!disp_valid, "R1 disp_valid", disp_valid, 0);
        check(kid_ready, "R1 kid_ready", kid_ready, 1);
        check(sub_ready == '0, "R1 sub_ready", sub_ready, 0);

        // R2 / R3: per-queue order, round-robin across queues
        cur_req = "R2_R3";
        submit(3, 16'h0301); submit(3, 16'h0302); submit(3, 16'h0303);
        submit(7, 16'h0701); submit(7, 16'h0702); submit(20, 16'h1401);
        @(negedge clk);
        check(disp_valid && disp_desc == 16'h0301, "R3 first offer", disp_desc, 16'h0301);
        expect_desc(16'h0301); expect_desc(16'h0701); expect_desc(16'h1401);
        expect_desc(16'h0302); expect_desc(16'h0702); expect_desc(16'h0303);
        @(posedge clk); #1 disp_ready = 1'b1;
        drain();
        disp_ready = 1'b0;
        complete(id_of[16'h0301]); complete(id_of[16'h0302]); complete(id_of[16'h0303]);
        complete(id_of[16'h0701]); complete(id_of[16'h0702]); complete(id_of[16'h1401]);

        // R5: concurrent host submits, admission pointer sits at 21
        cur_req = "R5";
        @(posedge clk); #1;
        sub_valid[1] = 1'b1; sub_desc[1] = 16'h0101;
        sub_valid[2] = 1'b1; sub_desc[2] = 16'h0201;
        @(negedge clk);
        check(sub_ready == 32'h2, "R5 grant q1", sub_ready, 32'h2);
        @(posedge clk); #1 sub_valid[1] = 1'b0;
        @(negedge clk);
        check(sub_ready == 32'h4, "R5 grant q2", sub_ready, 32'h4);
        @(posedge clk); #1 sub_valid[2] = 1'b0;
        expect_desc(16'h0101); expect_desc(16'h0201);
        disp_ready = 1'b1;
        drain();
        disp_ready = 1'b0;
        complete(id_of[16'h0101]); complete(id_of[16'h0201]);

        // R4 / R8: child precedence and parent suspension
        cur_req = "R4";
        expect_desc(16'h0901);
        disp_ready = 1'b1;
        submit(9, 16'h0901);
        drain();
        disp_ready = 1'b0;
        pid = id_of[16'h0901];
        @(posedge clk); #1;
        kid_valid = 1'b1; kid_parent = IW'(pid); kid_desc = 16'h8001;
        sub_valid[10] = 1'b1; sub_desc[10] = 16'h0A01;
        @(negedge clk);
        check(kid_ready && sub_ready == '0, "R5 child wins admission", sub_ready, 0);
        @(posedge clk); #1 kid_valid = 1'b0;
        @(negedge clk);
        check(sub_ready[10], "R5 host admitted after child", sub_ready, 32'h400);
        @(posedge clk); #1 sub_valid[10] = 1'b0;
        @(negedge clk);
        check(disp_valid && disp_desc == 16'h8001, "R4 child ahead of host", disp_desc, 16'h8001);
        expect_desc(16'h8001); expect_desc(16'h0A01);
        @(posedge clk); #1 disp_ready = 1'b1;
        drain();
        cur_req = "R8";
        complete(pid);
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            check(!disp_valid, "R8 parent suspended", disp_valid, 0);
        end
        expect_desc(16'h0901);
        complete(id_of[16'h8001]);
        drain();
        check(id_of[16'h0901] == pid, "R8 resume same id", id_of[16'h0901], pid);
        complete(pid);
        complete(id_of[16'h0A01]);

        // R8: two children, parent waits for both
        expect_desc(16'h0B01);
        submit(11, 16'h0B01);
        drain();
        pid2 = id_of[16'h0B01];
        expect_desc(16'h8101); expect_desc(16'h8102);
        spawn(pid2, 16'h8101);
        spawn(pid2, 16'h8102);
        drain();
        complete(pid2);
        complete(id_of[16'h8101]);
        for (int k = 0; k < 2; k++) begin
            @(negedge clk);
            check(!disp_valid, "R8 one child left", disp_valid, 0);
        end
        expect_desc(16'h0B01);
        complete(id_of[16'h8102]);
        drain();
        check(id_of[16'h0B01] == pid2, "R8 resume same id", id_of[16'h0B01], pid2);
        complete(pid2);

        // R6 / R7 / R9: fill the table under pause
        cur_req = "R7";
        disp_ready = 1'b0;
        pause = 1'b1;
        for (int i = 0; i < DEP; i++) begin
            submit(i % 4, DW'(16'h4000 + i));
        end
        fork
            submit(5, 16'h5001);
        join_none
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            check(!sub_ready[5] && !kid_ready, "R6 full blocks", sub_ready, 0);
        end
        @(posedge clk); #1 disp_ready = 1'b1;
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            check(!disp_valid, "R7 paused", disp_valid, 0);
        end
        for (int i = 0; i < DEP; i++) begin
            expect_desc(DW'(16'h4000 + i));
        end
        @(posedge clk); #1 pause = 1'b0;
        drain();
        cur_req = "R9";
        check(id_of[16'h4000] == 0, "R9 first slot", id_of[16'h4000], 0);
        expect_desc(16'h5001);
        complete(id_of[16'h4000]);
        drain();
        check(id_of[16'h5001] == 0, "R9 freed id reused", id_of[16'h5001], 0);
        for (int i = 1; i < DEP; i++) begin
            complete(id_of[16'h4000 + i]);
        end
        complete(id_of[16'h5001]);
        repeat (3) @(negedge clk);
        check(!disp_valid && kid_ready, "R9 table empty", disp_valid, 0);

        summary();
    end

endmodule